// File: doc/BRIEF.md
# Cartridge SRAM Write-Back Controller

This block connects a 6507-style cartridge port to an asynchronous SRAM so that cartridge code can both read and write that memory, although the port has no read/write line. The block runs from a fast oversampling clock. It finds CPU cycle boundaries by synchronizing the phase-2 clock. On every access with address bit 12 set, it fetches the addressed byte from SRAM and places it on the port data bus.

In write-back mode the block drives the fetched byte only while phase-2 is low. It releases the bus at the phase-2 rising edge, and a modelled bus keeper then holds the last value. If the CPU writes, its byte replaces the held value. Late in the cycle the block writes whatever the bus carries back to SRAM at the unchanged address, so a CPU read rewrites the same byte. In plain mode the byte is driven for the whole cycle and nothing is written. A range input limits write-back either to the whole cartridge space or to a low window of it. Outside that window an access behaves as a plain read.

Top module: `cart_magic_write`

## Requirements
- R1: After reset, and until the first decoded cycle, `port_oe` is 0 and `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1.
- R2: A cycle whose address has bit 12 = 0 leaves `port_oe` at 0 and all three SRAM strobes at 1 for the whole cycle.
- R3: In plain mode (`magic_en` = 0), a cartridge cycle drives `port_dout` = SRAM byte with `port_oe` = 1 and `sram_oe_n` = 0 in both phase-2 halves, and never asserts `sram_we_n`.
- R4: In write-back mode, the port is driven with the SRAM byte while phase-2 is low, and `port_oe` drops in the fast clock after the synchronized phase-2 rise.
- R5: While neither the block nor the CPU (`cpu_drv` = 1) drives the bus, `bus_level` holds its last driven value. A CPU drive replaces it with `cpu_wdata`.
- R6: Every write-back cycle writes the bus value into SRAM at the cycle's address. A CPU write stores `cpu_wdata`, and a CPU read leaves the stored byte unchanged.
- R7: `sram_oe_n` and `sram_we_n` are never both 0 in one fast clock. `sram_we_n` is back at 1 at least one fast clock before the next cycle's strobes or address start.
- R8: With `full_range` = 0, write-back applies only to offsets below `WIN_SIZE` (0x080 by default). At offset `WIN_SIZE` and above, the cycle is a plain read and the CPU's byte is not stored.
- R9: `magic_en` and `full_range` are sampled only at the cycle boundary (phase-2 fall). A change in mid-cycle takes effect from the next cycle.
- R10: `sram_addr` equals address bits 11:0 latched at the cycle boundary, and it stays stable while `sram_we_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU phase-2 clock, asynchronous |
| cpu_addr | input | 13 | Cartridge port address |
| cpu_drv | input | 1 | CPU is driving the data bus |
| cpu_wdata | input | 8 | Byte the CPU drives |
| magic_en | input | 1 | 1 = write-back mode, 0 = plain read mode |
| full_range | input | 1 | 1 = write-back over the whole cartridge space, 0 = low window only |
| port_dout | output | 8 | Byte the block drives onto the port |
| port_oe | output | 1 | Port data tristate enable |
| bus_level | output | 8 | Resolved port bus value, including the keeper |
| sram_addr | output | 12 | SRAM address |
| sram_rdata | input | 8 | SRAM read data |
| sram_wdata | output | 8 | SRAM write data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds the block with `HALF_CLKS` = 6 and `WE_GAP` = 1. This gives a short CPU cycle in which the synchronizer latency, the one-clock gap after release and the write strobe all fall within a few fast clocks. The tight placement of the strobe before the next boundary can then be checked directly. `WIN_SIZE` keeps its default of 128, so offsets 0x07F and 0x080 probe both sides of the window edge.

// File: rtl/cart_mw_pkg.sv
package cart_mw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FULL  = 2'd1,
    PH_FRONT = 2'd2,
    PH_BACK  = 2'd3
  } cyc_ph_t;

endpackage

// File: rtl/mw_phase_sync.sv
module mw_phase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi2_async,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= phi2_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/mw_range_decode.sv
module mw_range_decode #(
  parameter int ADDR_W   = 13,
  parameter int WIN_SIZE = 128,
  localparam int OFF_W   = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              magic_en,
  input  logic              full_range,
  output logic              is_cart,
  output logic              wb_en,
  output logic [OFF_W-1:0]  offset
);

  logic in_win;

  always_comb begin
    is_cart = addr[ADDR_W-1];
    offset  = addr[OFF_W-1:0];
    in_win  = ({1'b0, offset} < (OFF_W+1)'(WIN_SIZE));
    wb_en   = is_cart & magic_en & (full_range | in_win);
  end

endmodule

// File: rtl/mw_bus_keeper.sv
module mw_bus_keeper #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_ctl,
  input  logic [DATA_W-1:0] dout_ctl,
  input  logic              drv_cpu,
  input  logic [DATA_W-1:0] din_cpu,
  output logic [DATA_W-1:0] level
);

  logic [DATA_W-1:0] hold_q;
  logic              load_en;

  always_comb begin
    load_en = drv_ctl | drv_cpu;
    if (drv_ctl)      level = dout_ctl;
    else if (drv_cpu) level = din_cpu;
    else              level = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (load_en) hold_q <= level;
  end

endmodule

// File: rtl/cart_magic_write.sv
module cart_magic_write
  import cart_mw_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int WIN_SIZE    = 128,
  parameter int HALF_CLKS   = 8,
  parameter int WE_GAP      = 1,
  parameter int SYNC_STAGES = 2,
  localparam int OFF_W      = ADDR_W - 1,
  localparam int WE_END     = HALF_CLKS - 1,
  localparam int CNT_W      = $clog2(HALF_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_drv,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              magic_en,
  input  logic              full_range,
  output logic [DATA_W-1:0] port_dout,
  output logic              port_oe,
  output logic [DATA_W-1:0] bus_level,
  output logic [OFF_W-1:0]  sram_addr,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);

  logic             rise_w, fall_w;
  logic             is_cart_w, wb_en_w;
  logic [OFF_W-1:0] off_w;
  cyc_ph_t          ph_q, ph_d;
  logic [OFF_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_front;
  logic             we_on;

  mw_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .phi2_async(phi2), .rise(rise_w), .fall(fall_w)
  );

  mw_range_decode #(.ADDR_W(ADDR_W), .WIN_SIZE(WIN_SIZE)) u_dec (
    .addr(cpu_addr), .magic_en(magic_en), .full_range(full_range),
    .is_cart(is_cart_w), .wb_en(wb_en_w), .offset(off_w)
  );

  // next-state
  always_comb begin
    ph_d   = ph_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (fall_w) begin
      addr_d = off_w;
      cnt_d  = '0;
      if (!is_cart_w)   ph_d = PH_IDLE;
      else if (wb_en_w) ph_d = PH_FRONT;
      else              ph_d = PH_FULL;
    end else if (ph_q == PH_FRONT && rise_w) begin
      ph_d  = PH_BACK;
      cnt_d = '0;
    end else if (ph_q == PH_BACK && cnt_q != CNT_W'(HALF_CLKS)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    in_front  = (ph_q == PH_FRONT);
    port_oe   = (ph_q == PH_FULL) | in_front;
    port_dout = sram_rdata;
    we_on     = (ph_q == PH_BACK) && (cnt_q >= CNT_W'(WE_GAP)) &&
                (cnt_q < CNT_W'(WE_END));
    sram_ce_n = (ph_q == PH_IDLE);
    sram_oe_n = ~port_oe;
    sram_we_n = ~we_on;
    sram_addr = addr_q;
  end

  mw_bus_keeper #(.DATA_W(DATA_W)) u_keep (
    .clk(clk), .rst_n(rst_n), .drv_ctl(port_oe), .dout_ctl(port_dout),
    .drv_cpu(cpu_drv), .din_cpu(cpu_wdata), .level(bus_level)
  );

  assign sram_wdata = bus_level;

endmodule

// File: rtl/cart_magic_write_chk.sv
module cart_magic_write_chk #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_oe,
  input logic              cpu_drv,
  input logic [DATA_W-1:0] bus_level,
  input logic [OFF_W-1:0]  sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              rise_w,
  input logic              in_front
);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

  // R7
  we_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> $past(sram_we_n));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (!port_oe && sram_oe_n && sram_we_n));

  // R3
  drive_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe |-> (!sram_oe_n && !sram_ce_n));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_front && rise_w) |=> !port_oe);

  // R5
  keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_oe && !cpu_drv) |=> (port_oe || cpu_drv || $stable(bus_level)));

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_addr));

endmodule

bind cart_magic_write cart_magic_write_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_oe(port_oe), .cpu_drv(cpu_drv),
  .bus_level(bus_level), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .rise_w(rise_w),
  .in_front(in_front)
);

// File: tb/test_cart_magic_write.sv
`timescale 1ns/1ps
module test_cart_magic_write;

  localparam int HALF = 6;

  logic        clk, rst_n, phi2, cpu_drv, magic_en, full_range;
  logic [12:0] cpu_addr;
  logic [7:0]  cpu_wdata, port_dout, bus_level, sram_rdata, sram_wdata;
  logic        port_oe, sram_ce_n, sram_oe_n, sram_we_n;
  logic [11:0] sram_addr;

  logic [7:0] mem [0:4095];
  int n_chk, n_fail, we_seen, overlap;
  bit done;
  logic       lo_oe, lo_ce, lo_oen, hi_oe, hi_oen;
  logic [7:0] lo_dout, hi_bus;
  logic [11:0] lo_addr, hi_addr;

  cart_magic_write #(.HALF_CLKS(HALF), .WE_GAP(1)) i_cart_magic_write (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_drv(cpu_drv),
    .cpu_wdata(cpu_wdata), .magic_en(magic_en), .full_range(full_range),
    .port_dout(port_dout), .port_oe(port_oe), .bus_level(bus_level),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .sram_wdata(sram_wdata),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_wdata;

  always @(negedge clk) if (rst_n) begin
    if (!sram_we_n) we_seen++;
    if (!sram_oe_n && !sram_we_n) overlap++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one CPU cycle: low half then high half; samples taken 4 clocks into each
  task automatic bus_cycle(input logic [12:0] a, input bit wr, input logic [7:0] d,
                           input bit flip_mode);
    @(negedge clk);
    phi2 = 1'b0; cpu_addr = a; cpu_drv = 1'b0;
    wait_n(4);
    lo_oe = port_oe; lo_dout = port_dout; lo_ce = sram_ce_n;
    lo_oen = sram_oe_n; lo_addr = sram_addr;
    wait_n(HALF - 4);
    phi2 = 1'b1;
    if (flip_mode) magic_en = ~magic_en;
    if (wr) begin cpu_drv = 1'b1; cpu_wdata = d; end
    wait_n(4);
    hi_oe = port_oe; hi_bus = bus_level; hi_oen = sram_oe_n; hi_addr = sram_addr;
    wait_n(HALF - 5);
  endtask

  task automatic flush();
    bus_cycle(13'h0080, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_reset();
    chk(port_oe == 1'b0, "R1 port_oe", port_oe, 0);
    chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1 strobes",
        {sram_ce_n, sram_oe_n, sram_we_n}, 7);
  endtask

  task automatic t_noncart();
    magic_en = 1'b1; full_range = 1'b1; we_seen = 0;
    bus_cycle(13'h0123, 1'b1, 8'h55, 1'b0);
    chk(lo_oe == 0 && lo_ce == 1, "R2 low half", {lo_oe, lo_ce}, 1);
    chk(hi_oe == 0 && hi_oen == 1, "R2 high half", {hi_oe, hi_oen}, 1);
    flush();
    chk(we_seen == 0, "R2 no write", we_seen, 0);
  endtask

  task automatic t_plain();
    magic_en = 1'b0; full_range = 1'b1; we_seen = 0;
    bus_cycle(13'h1050, 1'b0, 8'h00, 1'b0);
    chk(lo_oe == 1 && lo_dout == mem[12'h050], "R3 low drive", lo_dout, mem[12'h050]);
    chk(hi_oe == 1 && hi_oen == 0, "R3 high drive", {hi_oe, hi_oen}, 2);
    chk(lo_addr == 12'h050, "R10 addr", lo_addr, 12'h050);
    flush();
    chk(we_seen == 0, "R3 no write", we_seen, 0);
  endtask

  task automatic t_magic_write();
    logic [7:0] old;
    magic_en = 1'b1; full_range = 1'b1; we_seen = 0;
    old = mem[12'h9A0];
    bus_cycle(13'h19A0, 1'b1, 8'hC3, 1'b0);
    chk(lo_oe == 1 && lo_dout == old, "R4 front drive", lo_dout, old);
    chk(hi_oe == 0, "R4 released", hi_oe, 0);
    chk(hi_bus == 8'hC3, "R5 cpu replaces", hi_bus, 8'hC3);
    chk(hi_addr == 12'h9A0, "R10 addr held", hi_addr, 12'h9A0);
    flush();
    chk(mem[12'h9A0] == 8'hC3, "R6 stored", mem[12'h9A0], 8'hC3);
    chk(we_seen > 0, "R6 strobe", we_seen, 1);
  endtask

  task automatic t_magic_read();
    logic [7:0] old;
    magic_en = 1'b1; full_range = 1'b1; we_seen = 0;
    old = mem[12'h321];
    bus_cycle(13'h1321, 1'b0, 8'h00, 1'b0);
    chk(hi_oe == 0 && hi_bus == old, "R5 keeper holds", hi_bus, old);
    flush();
    chk(mem[12'h321] == old, "R6 read rewrite", mem[12'h321], old);
    chk(we_seen > 0, "R6 read strobe", we_seen, 1);
  endtask

  task automatic t_window();
    logic [7:0] old;
    magic_en = 1'b1; full_range = 1'b0;
    bus_cycle(13'h107F, 1'b1, 8'hA5, 1'b0);
    flush();
    chk(mem[12'h07F] == 8'hA5, "R8 inside window", mem[12'h07F], 8'hA5);
    old = mem[12'h080];
    bus_cycle(13'h1080, 1'b1, 8'h3C, 1'b0);
    chk(hi_oe == 1, "R8 outside driven", hi_oe, 1);
    flush();
    chk(mem[12'h080] == old, "R8 outside not stored", mem[12'h080], old);
  endtask

  task automatic t_mode_sample();
    magic_en = 1'b0; full_range = 1'b1;
    bus_cycle(13'h1200, 1'b0, 8'h00, 1'b1);
    chk(hi_oe == 1, "R9 mid-cycle change ignored", hi_oe, 1);
    bus_cycle(13'h1201, 1'b1, 8'h77, 1'b0);
    chk(hi_oe == 0, "R9 next cycle write-back", hi_oe, 0);
    flush();
    chk(mem[12'h201] == 8'h77, "R9 next cycle stored", mem[12'h201], 8'h77);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i ^ (i >> 4) ^ 8'h5A);
    n_chk = 0; n_fail = 0; we_seen = 0; overlap = 0; done = 0;
    rst_n = 1'b0; phi2 = 1'b1; cpu_addr = '0; cpu_drv = 1'b0; cpu_wdata = '0;
    magic_en = 1'b0; full_range = 1'b1;
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_noncart();
    t_plain();
    t_magic_write();
    t_magic_read();
    t_window();
    t_mode_sample();
    chk(overlap == 0, "R7 oe/we overlap", overlap, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule